// File: doc/BRIEF.md
# Processor Interrupt Level Controller

This block holds one 8-bit control byte and turns it, together with two timer limit events, two serial controller requests and one floppy controller request, into a bank of individual interrupt level request lines for a processor. Bit 0 of the byte is a master enable. Three of its bits raise software interrupt levels directly. Two further bits let the two timers raise their own levels.

Each timer has a sticky limit-reached flag. The flag is set when the timer signals that it has hit its limit. It is cleared when software reads that timer's limit register. A timer level is raised only while its flag, its enable bit and the master enable are all set. Serial requests share one level that the master enable gates. The floppy request has its own level and follows the request line.

All level lines and flags are registered. They take their new value on the clock edge that samples the causing input or register write. Counting and priority encoding are done elsewhere.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset the control byte reads 0x00, both timer flags are 0 and every level line is 0.
- R2: A write stores the whole byte, and `rd_data` returns the stored byte unchanged, including bits 4 and 6, which have no function.
- R3: While control bit 0 (master enable) is 0, no level other than level 11 is asserted, whatever the flags, software bits or serial requests.
- R4: With the master enable set, control bits 1, 2 and 3 assert levels 1, 4 and 6 respectively, on the edge that stores the write.
- R5: Level 10 is asserted exactly when control bits 0 and 5 are both set and the timer 0 flag is set (enable mask 0x21).
- R6: Level 14 is asserted exactly when control bits 0 and 7 are both set and the timer 1 flag is set (enable mask 0x81).
- R7: Level 12 is asserted when the master enable is set and either serial request is high.
- R8: Level 11 follows the floppy request one edge later and does not depend on the master enable.
- R9: A pulse on `tmr_hit[i]` sets flag i. A pulse on `tmr_lim_rd[i]` clears flag i and drops that timer's level on the same edge. When both happen together, the hit wins.
- R10: Levels 0, 2, 3, 5, 7, 8, 9, 13 and 15 are never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Stored control byte |
| tmr_hit | input | 2 | Per-timer limit-reached pulse (bit i is timer i) |
| tmr_lim_rd | input | 2 | Per-timer limit register read pulse, clears the flag |
| tmr_flag | output | 2 | Per-timer limit-reached flags |
| ser_req | input | 2 | Serial controller requests |
| fd_req | input | 1 | Floppy controller request |
| irq_lvl | output | 16 | Level request lines, bit n is level n |

## Verification
The bench builds the block with its default 16-line level bank, which brings every mapped level (1, 4, 6, 10, 11, 12, 14) and every unmapped position into view at once. A reference model in the bench tracks the byte, the flags and the request inputs. It compares the whole level vector after every stimulus, so a stray or missing line at any position is caught. The bench also covers the collision of a timer hit with a limit read, and the master enable hiding every gated source at once.

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int LVL_W = 16,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [1:0]       tmr_hit,
  input  logic [1:0]       tmr_lim_rd,
  output logic [1:0]       tmr_flag,
  input  logic [1:0]       ser_req,
  input  logic             fd_req,
  output logic [LVL_W-1:0] irq_lvl
);
  localparam int B_MST = 0, B_S1 = 1, B_S4 = 2, B_S6 = 3, B_T0 = 5, B_T1 = 7;
  localparam int L_S1 = 1, L_S4 = 4, L_S6 = 6, L_T0 = 10, L_FD = 11, L_SER = 12, L_T1 = 14;
  localparam logic [LVL_W-1:0] USED = (LVL_W'(1) << L_S1) | (LVL_W'(1) << L_S4) |
    (LVL_W'(1) << L_S6) | (LVL_W'(1) << L_T0) | (LVL_W'(1) << L_FD) |
    (LVL_W'(1) << L_SER) | (LVL_W'(1) << L_T1);

  logic [DW-1:0]    ctl_q, ctl_d;
  logic [1:0]       flg_q, flg_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  assign ctl_d = wr_en ? wr_data : ctl_q;
  assign flg_d = (flg_q & ~tmr_lim_rd) | tmr_hit;

  always_comb begin
    lvl_d        = '0;
    lvl_d[L_S1]  = ctl_d[B_MST] & ctl_d[B_S1];
    lvl_d[L_S4]  = ctl_d[B_MST] & ctl_d[B_S4];
    lvl_d[L_S6]  = ctl_d[B_MST] & ctl_d[B_S6];
    lvl_d[L_T0]  = ctl_d[B_MST] & ctl_d[B_T0] & flg_d[0];
    lvl_d[L_T1]  = ctl_d[B_MST] & ctl_d[B_T1] & flg_d[1];
    lvl_d[L_SER] = ctl_d[B_MST] & (|ser_req);
    lvl_d[L_FD]  = fd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      flg_q <= '0;
      lvl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      flg_q <= flg_d;
      lvl_q <= lvl_d;
    end
  end

  assign rd_data  = ctl_q;
  assign tmr_flag = flg_q;
  assign irq_lvl  = lvl_q;

  a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[B_MST] |-> (lvl_q & ~(LVL_W'(1) << L_FD)) == '0);

  a_r8_floppy_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(fd_req) |=> lvl_q[L_FD] == $past(fd_req));

  a_r9_limit_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_lim_rd[0] && !tmr_hit[0]) |=> (!flg_q[0] && !lvl_q[L_T0]));

  a_r9_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_hit[1] |=> flg_q[1]);

  a_r6_timer1_gate: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q[L_T1] |-> (flg_q[1] && ctl_q[B_T1] && ctl_q[B_MST]));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  a_r10_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q & ~USED) == '0);
endmodule

// File: tb/irq_ctl_reg_bench.sv
module irq_ctl_reg_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, fd_req = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [1:0] tmr_hit = 0, tmr_lim_rd = 0, tmr_flag, ser_req = 0;
  logic [15:0] irq_lvl;
  int n_chk = 0, n_fail = 0;
  logic [7:0] m_ctl = 0;
  logic [1:0] m_flg = 0, m_ser = 0;
  logic m_fd = 0;

  always #10 clk = ~clk;

  irq_ctl_reg u_irq_ctl_reg (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .tmr_hit,
    .tmr_lim_rd, .tmr_flag, .ser_req, .fd_req, .irq_lvl);

  function automatic logic [15:0] exp_lvl();
    logic [15:0] e = 0;
    logic m = m_ctl[0];
    e[1]  = m & m_ctl[1];
    e[4]  = m & m_ctl[2];
    e[6]  = m & m_ctl[3];
    e[10] = m & m_ctl[5] & m_flg[0];
    e[14] = m & m_ctl[7] & m_flg[1];
    e[12] = m & (|m_ser);
    e[11] = m_fd;
    return e;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " levels"}, irq_lvl, exp_lvl());
    chk({tag, " byte"}, {8'h0, rd_data}, {8'h0, m_ctl});
    chk({tag, " flags"}, {14'h0, tmr_flag}, {14'h0, m_flg});
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; step(); wr_en = 0; m_ctl = d;
  endtask

  task automatic hit(logic [1:0] h, logic [1:0] r);
    tmr_hit = h; tmr_lim_rd = r; step(); tmr_hit = 0; tmr_lim_rd = 0;
    m_flg = (m_flg & ~r) | h;
  endtask

  task automatic t_reset();
    chk("R1 levels", irq_lvl, 16'h0);
    chk("R1 byte", {8'h0, rd_data}, 16'h0);
    chk("R1 flags", {14'h0, tmr_flag}, 16'h0);
  endtask

  task automatic t_readback();
    wr(8'h5A); check_all("R2 R3 readback 5A");
    wr(8'h50); check_all("R2 unused bits kept");
  endtask

  task automatic t_soft();
    wr(8'h03); check_all("R4 level1");
    wr(8'h05); check_all("R4 level4");
    wr(8'h09); check_all("R4 level6");
    wr(8'h0F); check_all("R4 all soft");
  endtask

  task automatic t_timer0();
    wr(8'h21); check_all("R5 no flag");
    hit(2'b01, 2'b00); check_all("R5 flag raises level10");
    wr(8'h01); check_all("R5 enable cleared");
    wr(8'h21); check_all("R5 enable restored");
    hit(2'b00, 2'b01); check_all("R9 limit read clears t0");
  endtask

  task automatic t_timer1();
    hit(2'b10, 2'b00); check_all("R6 flag without enable");
    wr(8'h81); check_all("R6 level14");
    hit(2'b10, 2'b10); check_all("R9 hit wins on collision");
    hit(2'b00, 2'b10); check_all("R9 limit read clears t1");
  endtask

  task automatic t_serial();
    wr(8'h01);
    ser_req = 2'b01; m_ser = 2'b01; step(); check_all("R7 serial A");
    ser_req = 2'b10; m_ser = 2'b10; step(); check_all("R7 serial B");
    ser_req = 2'b11; m_ser = 2'b11; step(); check_all("R7 serial both");
  endtask

  task automatic t_master_off();
    hit(2'b11, 2'b00);
    wr(8'hAE); check_all("R3 master off all sources");
    wr(8'hFF); check_all("R10 everything on");
    chk("R10 unused lines", irq_lvl & 16'hA3AD, 16'h0);
    ser_req = 0; m_ser = 0; step(); check_all("R7 serial released");
  endtask

  task automatic t_floppy();
    wr(8'h00);
    fd_req = 1; m_fd = 1; step(); check_all("R8 floppy high master off");
    fd_req = 0; m_fd = 0; step(); check_all("R8 floppy low");
  endtask

  initial begin
    fork
      begin
        #35 rst_n = 1;
        step();
        t_reset(); t_readback(); t_soft(); t_timer0(); t_timer1();
        t_serial(); t_master_off(); t_floppy();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule